// File: doc/BRIEF.md
# Credit-Gated Flit Transmitter

This block runs on the network clock between a transmit FIFO and the outbound link of a network-on-chip node. Whenever the FIFO holds a flit and the block still has credit for space at the destination, it pops that flit and puts it on the link one cycle later, with a valid strobe.

The block keeps an end-to-end credit count that stands for the free buffer slots at the far end. The count starts at the destination's slot count. It falls by one for every flit sent, and it rises as the far end reports consumed flits. The far end reports them in two ways: a one-credit strobe on a dedicated credit wire, or a multi-credit field carried by an incoming response. When the count is zero, sending stops until credit comes back.

A surplus return would push the count above the destination's capacity. In that case the count is clamped at the starting value and a sticky error flag is raised.

Top module: `credit_flit_tx`

## Requirements
- R1: After reset, `credits` equals CREDIT_INIT, `tx_valid` is 0 and `credit_overflow` is 0.
- R2: `fifo_pop` is 1 in a cycle exactly when `fifo_empty` is 0 and `credits` is non-zero. It is combinational, so it shows in the same cycle.
- R3: The word on `fifo_data` in a cycle where `fifo_pop` is 1 appears on `tx_flit`, with `tx_valid` at 1, after the next clock edge. `tx_valid` is 0 after an edge at which no pop took place.
- R4: With no credit returned, each pop lowers `credits` by one at the next edge.
- R5: While `credits` is 0, no flit is popped. A credit returned in a cycle with a zero count permits a pop only from the next cycle on.
- R6: Each cycle with `crd_return` at 1 adds one credit at the next edge.
- R7: When `rsp_valid` is 1, the value of `rsp_credits` (unsigned, RET_W bits) is added at the next edge. When `rsp_valid` is 0, `rsp_credits` has no effect.
- R8: A pop and a return in the same cycle give a next count of credits − 1 + returned. With one return of one credit, the count stays unchanged.
- R9: If the next count would exceed CREDIT_INIT, `credits` becomes CREDIT_INIT and `credit_overflow` becomes 1. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Transmit FIFO holds no flit |
| fifo_data | input | FLIT_W | Head flit of the FIFO (first-word fall-through) |
| fifo_pop | output | 1 | Removes the head flit this cycle |
| tx_valid | output | 1 | A flit is on the link this cycle |
| tx_flit | output | FLIT_W | Flit driven onto the link |
| crd_return | input | 1 | Dedicated one-credit return strobe |
| rsp_valid | input | 1 | Response carrying a credit field is present |
| rsp_credits | input | RET_W | Credits carried by the response |
| credits | output | CNT_W | Current credit count |
| credit_overflow | output | 1 | Sticky flag: surplus credit was returned |

## Verification
The bench builds the block with FLIT_W=16, CREDIT_INIT=4 and RET_W=2. With only four credits, the count is drained to zero within a few cycles, so the stall and resume-next-cycle behaviour comes up again and again. A two-bit response field can return up to three credits at once; with the strobe that makes up to four. Surplus returns, and therefore clamping at the ceiling together with the sticky overflow flag, are frequent rather than rare. Resets placed between phases clear the flag, so every phase starts from the full credit count.

// File: rtl/credit_tx_pkg.sv
package credit_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_STALL = 2'd1,
        TX_SEND  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/credit_ledger.sv
module credit_ledger #(
    parameter int CREDIT_INIT = 4,
    parameter int RET_W       = 2,
    localparam int CNT_W      = $clog2(CREDIT_INIT + 1),
    localparam int SUM_W      = ((CNT_W > RET_W) ? CNT_W : RET_W) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             crd_return,
    input  logic             rsp_valid,
    input  logic [RET_W-1:0] rsp_credits,
    output logic [CNT_W-1:0] count,
    output logic             has_credit,
    output logic             overflow
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ledger_s;

    ledger_s          st_d, st_q;
    logic [SUM_W-1:0] ret_sum;
    logic [SUM_W-1:0] total;

    always_comb begin
        st_d    = st_q;
        ret_sum = SUM_W'(crd_return) + (rsp_valid ? SUM_W'(rsp_credits) : '0);
        total   = SUM_W'(st_q.cnt) + ret_sum - SUM_W'(take);
        if (total > SUM_W'(CREDIT_INIT)) begin
            st_d.cnt = CNT_W'(CREDIT_INIT);
            st_d.ovf = 1'b1;
        end else begin
            st_d.cnt = CNT_W'(total);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(CREDIT_INIT);
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.cnt;
    assign has_credit = (st_q.cnt != '0);
    assign overflow   = st_q.ovf;

    // R9
    credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CREDIT_INIT));

    // R5
    no_take_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count != '0));

    // R4
    take_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !crd_return && !rsp_valid) |=> (count == $past(count) - CNT_W'(1)));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/flit_launch.sv
module flit_launch
    import credit_tx_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [FLIT_W-1:0] fifo_data,
    input  logic              has_credit,
    output logic              fifo_pop,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_flit
);

    typedef struct packed {
        tx_state_e         state;
        logic [FLIT_W-1:0] flit;
    } launch_s;

    launch_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        fifo_pop = !fifo_empty && has_credit;
        if (fifo_pop) begin
            st_d.state = TX_SEND;
            st_d.flit  = fifo_data;
        end else if (!fifo_empty) begin
            st_d.state = TX_STALL;
        end else begin
            st_d.state = TX_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= TX_IDLE;
            st_q.flit  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = (st_q.state == TX_SEND);
    assign tx_flit  = st_q.flit;

    // R2
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R3
    valid_follows_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(fifo_pop));

    // R3
    flit_matches_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (tx_flit == $past(fifo_data)));

endmodule

// File: rtl/credit_flit_tx.sv
module credit_flit_tx #(
    parameter int FLIT_W      = 16,
    parameter int CREDIT_INIT = 4,
    parameter int RET_W       = 2,
    localparam int CNT_W      = $clog2(CREDIT_INIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [FLIT_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              crd_return,
    input  logic              rsp_valid,
    input  logic [RET_W-1:0]  rsp_credits,
    output logic [CNT_W-1:0]  credits,
    output logic              credit_overflow
);

    logic have_credit;

    credit_ledger #(
        .CREDIT_INIT (CREDIT_INIT),
        .RET_W       (RET_W)
    ) ledger_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (fifo_pop),
        .crd_return  (crd_return),
        .rsp_valid   (rsp_valid),
        .rsp_credits (rsp_credits),
        .count       (credits),
        .has_credit  (have_credit),
        .overflow    (credit_overflow)
    );

    flit_launch #(
        .FLIT_W (FLIT_W)
    ) launch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .has_credit (have_credit),
        .fifo_pop   (fifo_pop),
        .tx_valid   (tx_valid),
        .tx_flit    (tx_flit)
    );

endmodule

// File: tb/credit_flit_tx_tb.sv
module credit_flit_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FLIT_W     = 16;
    localparam int INIT       = 4;
    localparam int RET_W      = 2;
    localparam int CNT_W      = $clog2(INIT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fifo_empty = 1'b1;
    logic [FLIT_W-1:0] fifo_data = '0;
    logic              fifo_pop;
    logic              tx_valid;
    logic [FLIT_W-1:0] tx_flit;
    logic              crd_return = 1'b0;
    logic              rsp_valid = 1'b0;
    logic [RET_W-1:0]  rsp_credits = '0;
    logic [CNT_W-1:0]  credits;
    logic              credit_overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    int          m_cred;
    bit          m_valid;
    logic [FLIT_W-1:0] m_flit;
    bit          m_ovf;
    string       m_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    credit_flit_tx #(
        .FLIT_W      (FLIT_W),
        .CREDIT_INIT (INIT),
        .RET_W       (RET_W)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_empty      (fifo_empty),
        .fifo_data       (fifo_data),
        .fifo_pop        (fifo_pop),
        .tx_valid        (tx_valid),
        .tx_flit         (tx_flit),
        .crd_return      (crd_return),
        .rsp_valid       (rsp_valid),
        .rsp_credits     (rsp_credits),
        .credits         (credits),
        .credit_overflow (credit_overflow)
    );

    function automatic bit exp_pop(bit empty, int cred);
        return !empty && (cred > 0);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        check(tx_valid == m_valid, "R3", "tx_valid", tx_valid, m_valid);
        if (m_valid)
            check(tx_flit == m_flit, "R3", "tx_flit", tx_flit, m_flit);
        check(int'(credits) == m_cred, m_tag, "credits", credits, m_cred);
        check(credit_overflow == m_ovf, "R9", "overflow", credit_overflow, m_ovf);
    endtask

    // one cycle: called right after a negedge
    task automatic step(bit empty, logic [FLIT_W-1:0] data, bit strobe,
                        bit rv, logic [RET_W-1:0] rc);
        bit p;
        int ret, nxt;
        check_outputs();
        fifo_empty  = empty;
        fifo_data   = data;
        crd_return  = strobe;
        rsp_valid   = rv;
        rsp_credits = rc;
        #1;
        p = exp_pop(empty, m_cred);
        check(fifo_pop == p, (!empty && m_cred == 0) ? "R5" : "R2",
              "fifo_pop", fifo_pop, p);
        ret = int'(strobe) + (rv ? int'(rc) : 0);
        nxt = m_cred + ret - int'(p);
        if (nxt > INIT) begin
            m_tag = "R9";
            nxt   = INIT;
            m_ovf = 1'b1;
        end else if (p && ret > 0)       m_tag = "R8";
        else if (rv)                     m_tag = "R7";
        else if (strobe)                 m_tag = "R6";
        else if (rc != '0)               m_tag = "R7";
        else if (p)                      m_tag = "R4";
        else                             m_tag = "R5";
        m_cred  = nxt;
        m_valid = p;
        if (p) m_flit = data;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        fifo_empty  = 1'b1;
        crd_return  = 1'b0;
        rsp_valid   = 1'b0;
        rsp_credits = '0;
        repeat (2) @(negedge clk);
        rst_n   = 1'b1;
        m_cred  = INIT;
        m_valid = 1'b0;
        m_ovf   = 1'b0;
        m_tag   = "R1";
        // R1 reset state
        check(int'(credits) == INIT, "R1", "credits", credits, INIT);
        check(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
        check(credit_overflow == 1'b0, "R1", "overflow", credit_overflow, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R4/R5: drain all credits with a full FIFO, then stall
        for (int i = 0; i < INIT + 2; i++)
            step(1'b0, FLIT_W'(16'hA000 + i), 1'b0, 1'b0, '0);
        // R7: field ignored without rsp_valid, still stalled
        step(1'b0, 16'hB001, 1'b0, 1'b0, 2'd3);
        step(1'b0, 16'hB002, 1'b0, 1'b0, 2'd0);
        // R5/R6: strobe at zero, pop only the next cycle
        step(1'b0, 16'hB003, 1'b1, 1'b0, '0);
        // R8: pop with one credit back keeps the count
        step(1'b0, 16'hB004, 1'b1, 1'b0, '0);
        step(1'b0, 16'hB005, 1'b0, 1'b0, '0);
        // R7: response returns three credits
        step(1'b1, 16'h0000, 1'b0, 1'b1, 2'd3);
        step(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        // R9: surplus return clamps and sets the flag
        step(1'b1, 16'h0000, 1'b1, 1'b1, 2'd3);
        step(1'b1, 16'h0000, 1'b0, 1'b0, '0);
        step(1'b0, 16'hC001, 1'b0, 1'b0, '0);
        step(1'b1, 16'h0000, 1'b0, 1'b0, '0);

        // random phases, each starting from reset
        for (int ph = 0; ph < 6; ph++) begin
            do_reset();
            for (int n = 0; n < 400; n++) begin
                bit e, s, rv;
                e  = ($urandom % 4) == 0;
                s  = ($urandom % (3 + ph)) == 0;
                rv = ($urandom % (4 + 2 * ph)) == 0;
                step(e, FLIT_W'($urandom), s, rv, RET_W'($urandom));
            end
        end
        check_outputs();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule